// File: doc/BRIEF.md
# Query Result Reuse Cache

This block remembers the answers to whole lookup queries. A query is described by a short tuple of 32-bit header fields, and the answer is one data word. Each hardware thread of a packet engine streams its header fields into the block one write at a time. Every field is ANDed with a per-position mask, and the masked fields form the tuple. When a thread delivers the last field of its tuple, the block hashes the tuple to a line of a direct-mapped store and compares the complete stored tuple with the new one.

On a hit the block returns the stored answer together with the requesting thread's jump address, so that the engine can skip the query walk and resume at its post-processing code. On a miss the block keeps the tuple for that thread. Later the thread reaches its post-processing point and reports the answer it computed, with its program counter. If that counter equals the thread's jump address, the tuple and the answer are written into the line.

A configuration port sets the field masks, the tuple length and the jump address of each thread. A global invalidate input empties the store. After reset every mask is all ones, the tuple length is the maximum, every jump address is zero and every line is invalid.

Top module: `reuse_cache_top`

## Requirements
- R1: After reset `rsp_valid` is low and every line is invalid, so any first lookup, including an all-zero tuple, misses.
- R2: A configuration write with `cfg_sel`=0 sets the mask of field position `cfg_idx`. A field written at position j is ANDed with mask j before it enters the tuple, so bits cleared in the mask never change the result.
- R3: A configuration write with `cfg_sel`=1 sets the tuple length L. A thread's L-th field write triggers a lookup, and that thread's field count restarts at zero. Each thread counts its own fields, so interleaved writes from different threads do not mix.
- R4: A lookup triggered by a field write in cycle c produces exactly one response with `rsp_valid` high in cycle c+2, and `rsp_tid` gives the thread.
- R5: The line index is the XOR of all masked fields of the tuple, folded to 6 bits by XOR of its 6-bit slices taken from bit 0 upward. The store has 64 direct-mapped lines. A hit requires the whole stored tuple to equal the lookup tuple.
- R6: On a hit, `rsp_hit` is 1, `rsp_data` is the stored answer, and `rsp_target` is the thread's jump address. That address is set by a configuration write with `cfg_sel`=2 and `cfg_idx`= thread.
- R7: On a miss, `rsp_hit`, `rsp_data` and `rsp_target` are 0 and the thread's tuple is retained. A `post_valid` cycle for that thread whose `post_pc` equals its jump address writes the tuple and `post_result` into the line, and later lookups of that tuple hit.
- R8: A post-processing report whose `post_pc` differs from the thread's jump address, or for a thread with no retained miss, writes nothing.
- R9: A fill into a line that already holds another tuple overwrites it, and the earlier tuple then misses.
- R10: `flush` invalidates every line in one cycle and wins over a fill in the same cycle. A lookup whose compare cycle coincides with the flush still sees the old contents.
- R11: A length write of 0 is stored as 1, and a length write above 5 is stored as 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 field mask, 1 tuple length, 2 jump address |
| cfg_idx | input | 3 | Field position or thread number |
| cfg_wdata | input | 32 | Configuration value |
| fld_valid | input | 1 | Header field write strobe |
| fld_tid | input | 2 | Thread writing the field |
| fld_data | input | 32 | Header field value |
| post_valid | input | 1 | Thread reports a post-processing result |
| post_tid | input | 2 | Reporting thread |
| post_pc | input | 16 | Program counter of the reporting thread |
| post_result | input | 32 | Query answer computed by the thread |
| flush | input | 1 | Invalidate all lines |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_tid | output | 2 | Thread of the response |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Stored answer on a hit, else 0 |
| rsp_target | output | 16 | Jump address on a hit, else 0 |

## Verification
The assertions watch the timing skeleton on every cycle. They check that a response follows each triggering field write two cycles later, that no response appears without one, that the response carries the thread that wrote the field, that a hit is never flagged without a response, that each per-thread field count stays inside the tuple, and that a flush leaves no valid line. Whether a given answer and jump address are the right ones depends on the history of fills, masks, overwrites and invalidates. Only the bench's scenarios can show that. The bench compares every cycle against a behavioural model through masked fields, interleaved threads, colliding tuples, rejected reports, length clamping and a flush racing a fill.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_LEN  = 2'd1,
    CFG_JUMP = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/rc_config.sv
module rc_config #(
  parameter int NT   = 4,
  parameter int NF   = 5,
  parameter int FW   = 32,
  parameter int AW   = 16,
  parameter int LW   = 3,
  parameter int SELW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [SELW-1:0]    cfg_idx,
  input  logic [FW-1:0]      cfg_wdata,
  output logic [NF*FW-1:0]   mask_flat,
  output logic [LW-1:0]      len_q,
  output logic [NT*AW-1:0]   jt_flat
);
  import rc_pkg::*;

  logic unused_hi;
  assign unused_hi = ^cfg_wdata[FW-1:AW];

  function automatic logic [LW-1:0] clamp_len(input logic [FW-1:0] v);
    if (v == '0) return LW'(1);
    if (v > FW'(NF)) return LW'(NF);
    return v[LW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_flat <= '1;
      len_q     <= LW'(NF);
      jt_flat   <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_MASK) begin
        for (int j = 0; j < NF; j++)
          if (cfg_idx == SELW'(j)) mask_flat[j*FW +: FW] <= cfg_wdata;
      end else if (cfg_sel == CFG_LEN) begin
        len_q <= clamp_len(cfg_wdata);
      end else if (cfg_sel == CFG_JUMP) begin
        for (int t = 0; t < NT; t++)
          if (cfg_idx == SELW'(t)) jt_flat[t*AW +: AW] <= cfg_wdata[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/rc_gather.sv
module rc_gather #(
  parameter int NT = 4,
  parameter int NF = 5,
  parameter int FW = 32,
  parameter int LW = 3,
  parameter int TW = 2,
  localparam int KW = NF*FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_valid,
  input  logic [TW-1:0]    fld_tid,
  input  logic [FW-1:0]    fld_data,
  input  logic [KW-1:0]    mask_flat,
  input  logic [LW-1:0]    len,
  output logic             trig,
  output logic [KW-1:0]    trig_key
);
  logic [LW-1:0] cnt_all  [NT];
  logic [FW-1:0] slot_all [NT][NF];
  logic [LW-1:0] cur_cnt;
  logic [FW-1:0] masked;

  assign cur_cnt = cnt_all[fld_tid];
  assign masked  = fld_data & mask_flat[int'(cur_cnt)*FW +: FW];
  assign trig    = fld_valid && (cur_cnt == LW'(len - 1'b1));

  always_comb begin
    trig_key = '0;
    for (int j = 0; j < NF; j++) begin
      if (LW'(j) < cur_cnt)       trig_key[j*FW +: FW] = slot_all[fld_tid][j];
      else if (LW'(j) == cur_cnt) trig_key[j*FW +: FW] = masked;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [LW-1:0] cnt_q;
    logic [FW-1:0] slot_q [NF];
    logic          mine;
    assign mine = fld_valid && (fld_tid == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        for (int j = 0; j < NF; j++) slot_q[j] <= '0;
      end else if (mine) begin
        if (trig) cnt_q <= '0;
        else begin
          slot_q[cur_cnt] <= masked;
          cnt_q           <= cnt_q + 1'b1;
        end
      end
    end

    assign cnt_all[t] = cnt_q;
    for (genvar j = 0; j < NF; j++) begin : g_slot
      assign slot_all[t][j] = slot_q[j];
    end

    // R3
    cnt_in_tuple_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < LW'(NF));
  end
endmodule

// File: rtl/rc_store.sv
module rc_store #(
  parameter int DEPTH = 64,
  parameter int KW    = 160,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_valid,
  output logic [KW-1:0]   rd_key,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [KW-1:0]   wr_key,
  input  logic [DW-1:0]   wr_data
);
  logic [DEPTH-1:0] valid_q;
  logic [KW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (flush) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_key;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_key   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/rc_pending.sv
module rc_pending #(
  parameter int NT = 4,
  parameter int KW = 160,
  parameter int IW = 6,
  parameter int TW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [TW-1:0]   upd_tid,
  input  logic            upd_miss,
  input  logic [KW-1:0]   upd_key,
  input  logic [IW-1:0]   upd_idx,
  input  logic            clr_en,
  input  logic [TW-1:0]   rd_tid,
  output logic            rd_v,
  output logic [KW-1:0]   rd_key,
  output logic [IW-1:0]   rd_idx
);
  logic          pv_q  [NT];
  logic [KW-1:0] pk_q  [NT];
  logic [IW-1:0] pi_q  [NT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        pv_q[t] <= 1'b0;
        pk_q[t] <= '0;
        pi_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (upd_en && upd_tid == TW'(t)) begin
          pv_q[t] <= upd_miss;
          if (upd_miss) begin
            pk_q[t] <= upd_key;
            pi_q[t] <= upd_idx;
          end
        end else if (clr_en && rd_tid == TW'(t)) begin
          pv_q[t] <= 1'b0;
        end
      end
    end
  end

  assign rd_v   = pv_q[rd_tid];
  assign rd_key = pk_q[rd_tid];
  assign rd_idx = pi_q[rd_tid];
endmodule

// File: rtl/reuse_cache_top.sv
module reuse_cache_top #(
  parameter int NT    = 4,
  parameter int NF    = 5,
  parameter int FW    = 32,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 64,
  localparam int TW   = $clog2(NT),
  localparam int LW   = $clog2(NF+1),
  localparam int SELW = (NT > NF) ? $clog2(NT) : $clog2(NF),
  localparam int IW   = $clog2(DEPTH),
  localparam int KW   = NF*FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [SELW-1:0] cfg_idx,
  input  logic [FW-1:0]   cfg_wdata,
  input  logic            fld_valid,
  input  logic [TW-1:0]   fld_tid,
  input  logic [FW-1:0]   fld_data,
  input  logic            post_valid,
  input  logic [TW-1:0]   post_tid,
  input  logic [AW-1:0]   post_pc,
  input  logic [DW-1:0]   post_result,
  input  logic            flush,
  output logic            rsp_valid,
  output logic [TW-1:0]   rsp_tid,
  output logic            rsp_hit,
  output logic [DW-1:0]   rsp_data,
  output logic [AW-1:0]   rsp_target
);
  function automatic logic [IW-1:0] fold_key(input logic [KW-1:0] k);
    logic [FW-1:0] x;
    logic [IW-1:0] r;
    x = '0;
    for (int j = 0; j < NF; j++) x ^= k[j*FW +: FW];
    r = '0;
    for (int c = 0; c < FW; c += IW) r ^= IW'(x >> c);
    return r;
  endfunction

  logic [KW-1:0]    mask_flat;
  logic [LW-1:0]    len_q;
  logic [NT*AW-1:0] jt_flat;

  rc_config #(.NT(NT), .NF(NF), .FW(FW), .AW(AW), .LW(LW), .SELW(SELW)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_idx, .cfg_wdata,
    .mask_flat, .len_q, .jt_flat
  );

  logic          lookup_trig;
  logic [KW-1:0] lookup_key;

  rc_gather #(.NT(NT), .NF(NF), .FW(FW), .LW(LW), .TW(TW)) u_gather (
    .clk, .rst_n, .fld_valid, .fld_tid, .fld_data,
    .mask_flat, .len(len_q), .trig(lookup_trig), .trig_key(lookup_key)
  );

  // stage 1: tuple and index registered
  logic          s1_v;
  logic [TW-1:0] s1_tid;
  logic [KW-1:0] s1_key;
  logic [IW-1:0] s1_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_tid <= '0; s1_key <= '0; s1_idx <= '0;
    end else begin
      s1_v <= lookup_trig;
      if (lookup_trig) begin
        s1_tid <= fld_tid;
        s1_key <= lookup_key;
        s1_idx <= fold_key(lookup_key);
      end
    end
  end

  // stage 2: compare against the line
  logic          line_v;
  logic [KW-1:0] line_key;
  logic [DW-1:0] line_data;
  logic          tag_match;
  logic          pend_v;
  logic [KW-1:0] pend_key;
  logic [IW-1:0] pend_idx;
  logic          fill_fire;

  assign tag_match = s1_v && line_v && (line_key == s1_key);
  assign fill_fire = post_valid && pend_v && (post_pc == jt_flat[int'(post_tid)*AW +: AW]);

  rc_store #(.DEPTH(DEPTH), .KW(KW), .DW(DW)) u_store (
    .clk, .rst_n, .flush,
    .rd_idx(s1_idx), .rd_valid(line_v), .rd_key(line_key), .rd_data(line_data),
    .wr_en(fill_fire), .wr_idx(pend_idx), .wr_key(pend_key), .wr_data(post_result)
  );

  rc_pending #(.NT(NT), .KW(KW), .IW(IW), .TW(TW)) u_pend (
    .clk, .rst_n,
    .upd_en(s1_v), .upd_tid(s1_tid), .upd_miss(!tag_match),
    .upd_key(s1_key), .upd_idx(s1_idx),
    .clr_en(fill_fire), .rd_tid(post_tid),
    .rd_v(pend_v), .rd_key(pend_key), .rd_idx(pend_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_tid <= '0; rsp_hit <= 1'b0;
      rsp_data <= '0; rsp_target <= '0;
    end else begin
      rsp_valid  <= s1_v;
      rsp_tid    <= s1_tid;
      rsp_hit    <= tag_match;
      rsp_data   <= tag_match ? line_data : '0;
      rsp_target <= tag_match ? jt_flat[int'(s1_tid)*AW +: AW] : '0;
    end
  end

  // R4
  resp_follows_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_trig |-> ##2 rsp_valid);
  // R4
  resp_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lookup_trig, 2));
  // R4
  resp_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_tid == $past(fld_tid, 2)));
  // R6
  hit_has_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  // R7
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_target == '0));
endmodule

// File: tb/sim_reuse_cache_top.sv
`timescale 1ns/1ps
module sim_reuse_cache_top;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        fld_valid = 0;
  logic [1:0]  fld_tid = 0;
  logic [31:0] fld_data = 0;
  logic        post_valid = 0;
  logic [1:0]  post_tid = 0;
  logic [15:0] post_pc = 0;
  logic [31:0] post_result = 0;
  logic        flush = 0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_tid;
  logic [31:0] rsp_data;
  logic [15:0] rsp_target;

  reuse_cache_top u0 (.*);

  int n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference
  bit           m_valid [64];
  logic [159:0] m_tag   [64];
  logic [31:0]  m_data  [64];
  logic [31:0]  m_mask  [5];
  int           m_len;
  logic [15:0]  m_jt    [4];
  logic [31:0]  m_q     [4][$];
  bit           m_pend  [4];
  logic [159:0] m_pkey  [4];
  int           m_pidx  [4];
  bit           s1v;
  int           s1t, s1i;
  logic [159:0] s1k;

  function automatic int hash_ref(logic [159:0] k);
    logic [31:0] x = 0;
    int r = 0;
    for (int j = 0; j < 5; j++) x = x ^ k[j*32 +: 32];
    for (int b = 0; b < 32; b++) if (x[b]) r = r ^ (1 << (b % 6));
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_valid[i] = 0;
    for (int j = 0; j < 5; j++) m_mask[j] = 32'hFFFF_FFFF;
    m_len = 5;
    for (int t = 0; t < 4; t++) begin
      m_jt[t] = 0; m_q[t].delete(); m_pend[t] = 0;
    end
    s1v = 0;
  endtask

  task automatic fail(string what, logic [159:0] act, logic [159:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
  endtask

  task automatic tick();
    bit ev = 0, eh = 0, pf, n_s1v = 0;
    int et = 0, n_s1t = 0, n_s1i = 0;
    logic [31:0] ed = 0;
    logic [15:0] ej = 0;
    logic [159:0] n_s1k = 0;
    if (s1v) begin
      ev = 1; et = s1t;
      eh = m_valid[s1i] && (m_tag[s1i] == s1k);
      if (eh) begin ed = m_data[s1i]; ej = m_jt[s1t]; end
    end
    pf = post_valid && m_pend[post_tid] && (post_pc == m_jt[post_tid]);
    if (fld_valid) begin
      m_q[fld_tid].push_back(fld_data & m_mask[m_q[fld_tid].size()]);
      if (m_q[fld_tid].size() == m_len) begin
        for (int j = 0; j < m_q[fld_tid].size(); j++) n_s1k[j*32 +: 32] = m_q[fld_tid][j];
        n_s1v = 1; n_s1t = fld_tid; n_s1i = hash_ref(n_s1k);
        m_q[fld_tid].delete();
      end
    end
    if (flush) for (int i = 0; i < 64; i++) m_valid[i] = 0;
    else if (pf) begin
      m_valid[m_pidx[post_tid]] = 1;
      m_tag[m_pidx[post_tid]]   = m_pkey[post_tid];
      m_data[m_pidx[post_tid]]  = post_result;
    end
    if (pf) m_pend[post_tid] = 0;
    if (s1v) begin
      m_pend[s1t] = !eh;
      if (!eh) begin m_pkey[s1t] = s1k; m_pidx[s1t] = s1i; end
    end
    if (cfg_we) begin
      if (cfg_sel == 0 && cfg_idx < 5) m_mask[cfg_idx] = cfg_wdata;
      if (cfg_sel == 1) m_len = (cfg_wdata == 0) ? 1 : (cfg_wdata > 5) ? 5 : int'(cfg_wdata);
      if (cfg_sel == 2 && cfg_idx < 4) m_jt[cfg_idx] = cfg_wdata[15:0];
    end
    s1v = n_s1v; s1t = n_s1t; s1k = n_s1k; s1i = n_s1i;
    @(posedge clk); @(negedge clk);
    cfg_we = 0; fld_valid = 0; post_valid = 0; flush = 0;
    n_vec++;
    if (rsp_valid !== ev) fail("rsp_valid", 160'(rsp_valid), 160'(ev));
    else if (ev) begin
      if (rsp_tid !== 2'(et)) fail("rsp_tid", 160'(rsp_tid), 160'(et));
      if (rsp_hit !== eh) fail("rsp_hit", 160'(rsp_hit), 160'(eh));
      if (rsp_data !== ed) fail("rsp_data", 160'(rsp_data), 160'(ed));
      if (rsp_target !== ej) fail("rsp_target", 160'(rsp_target), 160'(ej));
    end
  endtask

  task automatic cfg(int sel, int idx, logic [31:0] v);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = v; tick();
  endtask
  task automatic fld(int t, logic [31:0] v);
    fld_valid = 1; fld_tid = 2'(t); fld_data = v; tick();
  endtask
  task automatic post(int t, logic [15:0] pc, logic [31:0] v);
    post_valid = 1; post_tid = 2'(t); post_pc = pc; post_result = v; tick();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(2);
    for (int j = 0; j < 5; j++) fld(0, 0);
    idle(3);

    cur_req = "R3"; cfg(1, 0, 2);
    cur_req = "R2"; cfg(0, 1, 32'h0000_FFFF);
    cur_req = "R6";
    for (int t = 0; t < 4; t++) cfg(2, t, 32'h100 * (t + 1));

    cur_req = "R7";
    fld(0, 32'h0A0B_0C0D); fld(0, 32'h0000_1234); idle(2);
    post(0, 16'h0100, 32'hDEAD_BEEF); idle(1);
    cur_req = "R6";
    fld(0, 32'h0A0B_0C0D); fld(0, 32'h0000_1234); idle(2);
    cur_req = "R2";
    fld(0, 32'h0A0B_0C0D); fld(0, 32'hABCD_1234); idle(2);

    cur_req = "R8";
    fld(1, 32'h5555); fld(1, 32'h6666); idle(2);
    post(1, 16'h0999, 32'h1111);
    post(2, 16'h0300, 32'h2222);
    fld(1, 32'h5555); fld(1, 32'h6666); idle(2);
    post(1, 16'h0200, 32'h3333);
    fld(1, 32'h5555); fld(1, 32'h6666); idle(2);

    cur_req = "R3";
    fld(2, 32'hE); fld(3, 32'hF); fld(2, 32'h10); fld(3, 32'h11); idle(3);

    cur_req = "R5";
    fld(2, 1); fld(2, 0); idle(2); post(2, 16'h0300, 32'hAAAA);
    fld(3, 64); fld(3, 0); idle(2);
    fld(2, 1); fld(2, 0); idle(2);
    cur_req = "R9";
    post(3, 16'h0400, 32'hBBBB);
    fld(2, 1); fld(2, 0); idle(2);
    fld(3, 64); fld(3, 0); idle(2);

    cur_req = "R10";
    fld(0, 32'h0A0B_0C0D); fld(0, 32'h0000_1234);
    flush = 1; tick(); idle(2);
    fld(0, 32'h0A0B_0C0D); fld(0, 32'h0000_1234); idle(2);
    flush = 1; post_valid = 1; post_tid = 0; post_pc = 16'h0100; post_result = 32'h77; tick();
    fld(0, 32'h0A0B_0C0D); fld(0, 32'h0000_1234); idle(2);

    cur_req = "R11";
    cfg(1, 0, 0);
    fld(1, 32'h42); fld(1, 32'h42); idle(2);
    cfg(1, 0, 7);
    for (int j = 0; j < 5; j++) fld(3, 32'(j)); idle(3);

    cur_req = "R4"; cfg(1, 0, 2);
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[3:2] != 0) begin
        fld_valid = 1; fld_tid = seed[9:8]; fld_data = 32'(seed[13:12]) * 32'h1111;
      end
      if (seed[17:16] == 0) begin
        post_valid = 1; post_tid = seed[19:18];
        post_pc = seed[20] ? m_jt[seed[19:18]] : 16'h7;
        post_result = 32'(seed[31:24]);
      end
      if (seed[30:25] == 0) flush = 1;
      tick();
    end
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule